// File: doc/BRIEF.md
# Partitioned Performance Counter Bank

This block holds six 32-bit event counters. A boundary field, set at run time, splits them into two groups. Counters whose index is below the boundary form the guest group. Guest software at privilege levels 0 and 1 may use them, and level 2 may use them too. The remaining counters form the hypervisor group, which only level 2 may touch. Each group has its own count enable. A boundary written above six acts as six, but a level 2 read of the field returns the exact value that was stored.

Software reaches the bank through a one-cycle access port. A request carries a privilege level, a read/write flag, a register select and write data. One cycle later the block answers with one of three outcomes: ok, fault or trap. A write that is refused or trapped changes nothing. A hypervisor trap bit can redirect every level 0 or level 1 access to the guest control register to level 2. Each counter has an event input. When a counter wraps it raises a sticky overflow flag, which stays set until software writes that counter.

Top module: `pmu_part_bank`

## Requirements
- R1: After reset the boundary field is 6, the trap bit is 0, both group enables and the user-access bit are 0, and every counter and overflow flag is 0.
- R2: Each request gets a response exactly one cycle later, with status code 0 = ok, 1 = fault or 2 = trap. Read data is 0 unless the response is an ok read.
- R3: Counter n (select code n, 0..5) belongs to the guest group when n is below the effective boundary. Levels 1 and 2 may access it. Level 0 may access it only while the user-access bit (select 7, bit 0) is 1.
- R4: A counter at or above the effective boundary may be accessed only from level 2. Levels 0 and 1 get a fault. Level code 3 always gets a fault.
- R5: A stored boundary greater than 6 behaves exactly like 6. A stored boundary of 0 gives levels 0 and 1 no counter.
- R6: A guest counter counts only while the guest enable (select 6, bit 0) is 1. A hypervisor-group counter counts only while the hypervisor enable (select 8, bit 6) is 1. A counter increments once for each clock edge on which its event input is high and its group is enabled.
- R7: A counter that increments from all ones wraps to 0 and sets its overflow flag. The flag stays set until an ok write to that counter clears it.
- R8: The hypervisor configuration register (select 8) may be accessed only from level 2. Its layout is boundary in bits [4:0], trap bit in bit 5 and hypervisor enable in bit 6. A read returns the boundary exactly as written.
- R9: While the trap bit is 1, every level 0 or level 1 access to the guest control register (select 6) returns trap. Otherwise levels 1 and 2 may access that register, and level 0 may access it only when the user-access bit is 1.
- R10: A write that returns fault or trap changes no counter and no control bit.
- R11: Levels 1 and 2 may access the user-access register (select 7). Level 0 gets a fault. Any select code above 8 gets a fault.
- R12: A write to a counter loads the written value, even if that counter's event input is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | Per-counter event inputs |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_level_i | input | 2 | Privilege level of the requester (0, 1, 2) |
| req_sel_i | input | 4 | Register select: 0..5 counters, 6 guest control, 7 user access, 8 hypervisor configuration |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_status_o | output | 2 | 0 ok, 1 fault, 2 trap |
| rsp_rdata_o | output | 32 | Read data on an ok read, else 0 |
| ovf_o | output | 6 | Sticky overflow flag of each counter |

## Verification
The access rules are exercised with a matrix of levels, selects and boundary values. The boundary is set to 2, to 0 and to 31. These settings separate a guest counter from a hypervisor-only counter, the empty guest group, and clamping that does not alter readback. The same select is then tried at levels 0, 1, 2 and 3 to show where the user-access bit and the trap bit change the outcome. Counting runs with the boundary at 3 and all events held high, first with only the hypervisor group enabled and then with both groups enabled. This shows that each group obeys only its own enable. Finally a wrap from all ones, and a write that lands together with an event, check the overflow flag and the write-over-event ordering.

// File: rtl/pmu_part_pkg.sv
package pmu_part_pkg;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_FAULT = 2'd1,
      ST_TRAP  = 2'd2
   } acc_status_e;

   typedef enum logic [2:0] {
      TGT_CNT  = 3'd0,
      TGT_GCTL = 3'd1,
      TGT_UEN  = 3'd2,
      TGT_HCFG = 3'd3,
      TGT_NONE = 3'd4
   } acc_target_e;

   localparam logic [1:0] LVL_USER = 2'd0;
   localparam logic [1:0] LVL_KERN = 2'd1;
   localparam logic [1:0] LVL_HYP  = 2'd2;

endpackage

// File: rtl/pmu_part_window.sv
module pmu_part_window #(
   parameter int NCNT = 6,
   parameter int BW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [BW-1:0]   bnd_raw,
   input  logic            guest_en,
   input  logic            hyp_en,
   output logic [NCNT-1:0] guest_mask,
   output logic [NCNT-1:0] run_mask
);
   localparam logic [BW-1:0] NCNT_B = BW'(NCNT);

   logic [BW-1:0] eff_bnd;
   assign eff_bnd = (bnd_raw > NCNT_B) ? NCNT_B : bnd_raw;

   for (genvar i = 0; i < NCNT; i++) begin : g_slot
      localparam logic [BW-1:0] IDX = BW'(i);
      assign guest_mask[i] = (IDX < eff_bnd);
      assign run_mask[i]   = guest_mask[i] ? guest_en : hyp_en;
   end

   AST_CLAMP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_raw >= NCNT_B) |-> (&guest_mask)); // R5
   AST_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_raw == '0) |-> (guest_mask == '0)); // R5
   AST_RUN_GATING: assert property (@(posedge clk) disable iff (!rst_n)
      (!guest_en && !hyp_en) |-> (run_mask == '0)); // R6

endmodule

// File: rtl/pmu_part_access.sv
module pmu_part_access
   import pmu_part_pkg::*;
#(
   parameter int NCNT = 6,
   parameter int SW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      lvl,
   input  logic [SW-1:0]   sel,
   input  logic [NCNT-1:0] guest_mask,
   input  logic            user_en,
   input  logic            trap_en,
   output acc_target_e     tgt,
   output acc_status_e     status
);
   localparam logic [SW-1:0] SEL_GCTL = SW'(NCNT);
   localparam logic [SW-1:0] SEL_UEN  = SW'(NCNT + 1);
   localparam logic [SW-1:0] SEL_HCFG = SW'(NCNT + 2);

   logic is_user, is_kern, is_hyp, in_guest, granted;

   assign is_user = (lvl == LVL_USER);
   assign is_kern = (lvl == LVL_KERN);
   assign is_hyp  = (lvl == LVL_HYP);

   always_comb begin
      tgt      = TGT_NONE;
      in_guest = 1'b0;
      for (int i = 0; i < NCNT; i++) begin
         if (sel == SW'(i)) begin
            tgt      = TGT_CNT;
            in_guest = guest_mask[i];
         end
      end
      if (sel == SEL_GCTL) tgt = TGT_GCTL;
      if (sel == SEL_UEN)  tgt = TGT_UEN;
      if (sel == SEL_HCFG) tgt = TGT_HCFG;
   end

   always_comb begin
      granted = 1'b0;
      status  = ST_FAULT;
      unique case (tgt)
         TGT_CNT:  granted = is_hyp || (in_guest && (is_kern || (is_user && user_en)));
         TGT_GCTL: granted = is_hyp || is_kern || (is_user && user_en);
         TGT_UEN:  granted = is_hyp || is_kern;
         TGT_HCFG: granted = is_hyp;
         default:  granted = 1'b0;
      endcase
      if (tgt == TGT_GCTL && trap_en && (is_user || is_kern)) status = ST_TRAP;
      else if (granted) status = ST_OK;
   end

   AST_HYP_ONLY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tgt == TGT_CNT && status == ST_OK && !in_guest) |-> is_hyp); // R4
   AST_TRAP_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && status == ST_TRAP) |-> (tgt == TGT_GCTL && !is_hyp)); // R9
   AST_HCFG_HYP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tgt == TGT_HCFG && status == ST_OK) |-> is_hyp); // R8
   AST_LVL3_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && lvl == 2'd3) |-> (status == ST_FAULT)); // R4

endmodule

// File: rtl/pmu_part_counter.sv
module pmu_part_counter #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_val,
   output logic [CW-1:0] cnt_o,
   output logic          ovf_o
);
   logic [CW-1:0] cnt_q;
   logic          ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (wr_en) begin
         cnt_q <= wr_val;
         ovf_q <= 1'b0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
         if (&cnt_q) ovf_q <= 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

   AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr_en) |=> $stable(cnt_q)); // R6
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_en) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_en && (&cnt_q)) |=> (ovf_q && cnt_q == '0)); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !wr_en) |=> ovf_q); // R7
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt_q == $past(wr_val) && !ovf_q)); // R12

endmodule

// File: rtl/pmu_part_bank.sv
module pmu_part_bank
   import pmu_part_pkg::*;
#(
   parameter int NCNT = 6,
   parameter int CW   = 32,
   parameter int DW   = 32,
   parameter int BW   = 5,
   parameter int SW   = 4,
   parameter int BND_RST = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCNT-1:0] evt_i,
   input  logic            req_valid_i,
   input  logic            req_write_i,
   input  logic [1:0]      req_level_i,
   input  logic [SW-1:0]   req_sel_i,
   input  logic [DW-1:0]   req_wdata_i,
   output logic            rsp_valid_o,
   output logic [1:0]      rsp_status_o,
   output logic [DW-1:0]   rsp_rdata_o,
   output logic [NCNT-1:0] ovf_o
);
   localparam int TRAP_BIT = BW;
   localparam int HEN_BIT  = BW + 1;

   if (NCNT < 1 || NCNT >= (1 << BW)) begin : g_bad_ncnt
      $error("NCNT must fit below the boundary field range");
   end
   if ((1 << SW) < NCNT + 3) begin : g_bad_sw
      $error("SW too narrow for all register selects");
   end
   if (DW < CW || DW < BW + 2) begin : g_bad_dw
      $error("DW narrower than a counter or the configuration layout");
   end

   logic [BW-1:0]   bnd_q;
   logic            trap_q, hen_q, gen_q, uen_q;
   logic [NCNT-1:0] guest_mask, run_mask;
   logic [CW-1:0]   cnt [NCNT];
   acc_target_e     tgt;
   acc_status_e     status;
   logic            acc_ok, acc_wr;
   logic [DW-1:0]   rd_mux;

   pmu_part_window #(.NCNT(NCNT), .BW(BW)) u_window (
      .clk(clk), .rst_n(rst_n), .bnd_raw(bnd_q), .guest_en(gen_q), .hyp_en(hen_q),
      .guest_mask(guest_mask), .run_mask(run_mask)
   );

   pmu_part_access #(.NCNT(NCNT), .SW(SW)) u_access (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid_i), .lvl(req_level_i),
      .sel(req_sel_i), .guest_mask(guest_mask), .user_en(uen_q), .trap_en(trap_q),
      .tgt(tgt), .status(status)
   );

   assign acc_ok = req_valid_i && (status == ST_OK);
   assign acc_wr = acc_ok && req_write_i;

   for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      logic wr_hit;
      assign wr_hit = acc_wr && (tgt == TGT_CNT) && (req_sel_i == SW'(i));
      pmu_part_counter #(.CW(CW)) u_cnt (
         .clk(clk), .rst_n(rst_n),
         .inc(evt_i[i] && run_mask[i]),
         .wr_en(wr_hit),
         .wr_val(req_wdata_i[CW-1:0]),
         .cnt_o(cnt[i]),
         .ovf_o(ovf_o[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bnd_q  <= BW'(BND_RST);
         trap_q <= 1'b0;
         hen_q  <= 1'b0;
         gen_q  <= 1'b0;
         uen_q  <= 1'b0;
      end else if (acc_wr) begin
         case (tgt)
            TGT_GCTL: gen_q <= req_wdata_i[0];
            TGT_UEN:  uen_q <= req_wdata_i[0];
            TGT_HCFG: begin
               bnd_q  <= req_wdata_i[BW-1:0];
               trap_q <= req_wdata_i[TRAP_BIT];
               hen_q  <= req_wdata_i[HEN_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_mux = '0;
      case (tgt)
         TGT_CNT: begin
            for (int i = 0; i < NCNT; i++)
               if (req_sel_i == SW'(i)) rd_mux = DW'(cnt[i]);
         end
         TGT_GCTL: rd_mux = DW'(gen_q);
         TGT_UEN:  rd_mux = DW'(uen_q);
         TGT_HCFG: rd_mux = DW'({hen_q, trap_q, bnd_q});
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_o  <= 1'b0;
         rsp_status_o <= ST_OK;
         rsp_rdata_o  <= '0;
      end else begin
         rsp_valid_o  <= req_valid_i;
         rsp_status_o <= req_valid_i ? status : ST_OK;
         rsp_rdata_o  <= (acc_ok && !req_write_i) ? rd_mux : '0;
      end
   end

   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> rsp_valid_o); // R2
   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && rsp_status_o != ST_OK) |-> (rsp_rdata_o == '0)); // R2
   AST_REFUSED_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_write_i && status != ST_OK) |=>
         ($stable(bnd_q) && $stable(trap_q) && $stable(hen_q) && $stable(gen_q) && $stable(uen_q))); // R10

endmodule

// File: tb/pmu_part_bank_test.sv
`timescale 1ns/1ps
module pmu_part_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  evt = '0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_level = '0;
   logic [3:0]  req_sel = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_status;
   logic [31:0] rsp_rdata;
   logic [5:0]  ovf;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pmu_part_bank uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .req_valid_i(req_valid),
      .req_write_i(req_write), .req_level_i(req_level), .req_sel_i(req_sel),
      .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status),
      .rsp_rdata_o(rsp_rdata), .ovf_o(ovf)
   );

   // entry: level, write, select, wdata, expected status, expected rdata
   localparam int NV = 29;
   localparam logic [72:0] VEC [NV] = '{
      {2'd2, 1'b1, 4'd8, 32'h02, 2'd0, 32'h00},  // R8 boundary := 2
      {2'd2, 1'b0, 4'd8, 32'h00, 2'd0, 32'h02},  // R8
      {2'd1, 1'b1, 4'd0, 32'h11, 2'd0, 32'h00},  // R3
      {2'd1, 1'b0, 4'd0, 32'h00, 2'd0, 32'h11},  // R3
      {2'd1, 1'b0, 4'd2, 32'h00, 2'd1, 32'h00},  // R4
      {2'd2, 1'b1, 4'd2, 32'h22, 2'd0, 32'h00},  // R4
      {2'd2, 1'b0, 4'd2, 32'h00, 2'd0, 32'h22},  // R4
      {2'd1, 1'b1, 4'd2, 32'h99, 2'd1, 32'h00},  // R10
      {2'd2, 1'b0, 4'd2, 32'h00, 2'd0, 32'h22},  // R10
      {2'd0, 1'b0, 4'd0, 32'h00, 2'd1, 32'h00},  // R3 user bit off
      {2'd1, 1'b1, 4'd7, 32'h01, 2'd0, 32'h00},  // R11
      {2'd0, 1'b0, 4'd0, 32'h00, 2'd0, 32'h11},  // R3 user bit on
      {2'd0, 1'b0, 4'd7, 32'h00, 2'd1, 32'h00},  // R11
      {2'd0, 1'b1, 4'd6, 32'h01, 2'd0, 32'h00},  // R9
      {2'd1, 1'b0, 4'd6, 32'h00, 2'd0, 32'h01},  // R9
      {2'd2, 1'b1, 4'd8, 32'h22, 2'd0, 32'h00},  // R9 trap on
      {2'd1, 1'b0, 4'd6, 32'h00, 2'd2, 32'h00},  // R9
      {2'd1, 1'b1, 4'd6, 32'h00, 2'd2, 32'h00},  // R9
      {2'd2, 1'b0, 4'd6, 32'h00, 2'd0, 32'h01},  // R10
      {2'd1, 1'b0, 4'd8, 32'h00, 2'd1, 32'h00},  // R8
      {2'd2, 1'b1, 4'd8, 32'h1F, 2'd0, 32'h00},  // R5 boundary := 31
      {2'd2, 1'b0, 4'd8, 32'h00, 2'd0, 32'h1F},  // R8 raw
      {2'd1, 1'b0, 4'd5, 32'h00, 2'd0, 32'h00},  // R5 clamps to 6
      {2'd2, 1'b1, 4'd8, 32'h00, 2'd0, 32'h00},  // R5 boundary := 0
      {2'd1, 1'b0, 4'd0, 32'h00, 2'd1, 32'h00},  // R5
      {2'd2, 1'b0, 4'd8, 32'h00, 2'd0, 32'h00},  // R8
      {2'd3, 1'b0, 4'd0, 32'h00, 2'd1, 32'h00},  // R4 level 3
      {2'd2, 1'b0, 4'd12, 32'h00, 2'd1, 32'h00}, // R11 unknown select
      {2'd2, 1'b1, 4'd8, 32'h06, 2'd0, 32'h00}   // restore boundary 6
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic acc(input logic [1:0] l, input logic w, input logic [3:0] s,
                      input logic [31:0] d, output logic [1:0] st, output logic [31:0] rd);
      req_valid = 1'b1; req_write = w; req_level = l; req_sel = s; req_wdata = d;
      @(negedge clk);
      st = rsp_status; rd = rsp_rdata;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
      end
   end

   initial begin
      logic [1:0]  st;
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 ovf", 32'(ovf), 32'h0);
      check("R2 idle valid", 32'(rsp_valid), 32'h0);
      acc(2'd2, 1'b0, 4'd8, 32'h0, st, rd);
      check("R1 hcfg", rd, 32'h06);
      check("R2 valid", 32'(rsp_valid), 32'h1);
      acc(2'd2, 1'b0, 4'd6, 32'h0, st, rd);
      check("R1 gctl", rd, 32'h0);
      acc(2'd2, 1'b0, 4'd3, 32'h0, st, rd);
      check("R1 counter3", rd, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [72:0] v;
         v = VEC[i];
         acc(v[72:71], v[70], v[69:66], v[65:34], st, rd);
         check($sformatf("R2 vec%0d status", i), 32'(st), 32'(v[33:32]));
         check($sformatf("R2 vec%0d rdata", i), rd, v[31:0]);
      end

      // R6 group gating: boundary 3, hypervisor enable on, guest enable off
      acc(2'd2, 1'b1, 4'd6, 32'h0, st, rd);
      acc(2'd2, 1'b1, 4'd8, 32'h43, st, rd);
      for (int c = 0; c < 6; c++) acc(2'd2, 1'b1, 4'(c), 32'h0, st, rd);
      evt = 6'h3F;
      repeat (10) @(negedge clk);
      evt = '0;
      acc(2'd2, 1'b0, 4'd0, 32'h0, st, rd);
      check("R6 guest disabled", rd, 32'd0);
      acc(2'd2, 1'b0, 4'd4, 32'h0, st, rd);
      check("R6 hyp enabled", rd, 32'd10);
      acc(2'd1, 1'b1, 4'd6, 32'h1, st, rd);
      evt = 6'h3F;
      repeat (5) @(negedge clk);
      evt = '0;
      acc(2'd1, 1'b0, 4'd0, 32'h0, st, rd);
      check("R6 guest enabled", rd, 32'd5);
      acc(2'd2, 1'b0, 4'd4, 32'h0, st, rd);
      check("R6 hyp continues", rd, 32'd15);

      // R7 wrap and sticky flag
      acc(2'd2, 1'b1, 4'd1, 32'hFFFF_FFFE, st, rd);
      evt = 6'b000010;
      repeat (2) @(negedge clk);
      evt = '0;
      check("R7 ovf set", 32'(ovf), 32'h02);
      acc(2'd2, 1'b0, 4'd1, 32'h0, st, rd);
      check("R7 wrapped value", rd, 32'h0);
      check("R7 ovf sticky", 32'(ovf), 32'h02);
      acc(2'd1, 1'b1, 4'd1, 32'h5, st, rd);
      check("R7 ovf cleared", 32'(ovf), 32'h0);

      // R12 write beats a simultaneous event
      evt = 6'b000001;
      acc(2'd2, 1'b1, 4'd0, 32'h100, st, rd);
      evt = '0;
      acc(2'd2, 1'b0, 4'd0, 32'h0, st, rd);
      check("R12 write wins", rd, 32'h100);

      // R10 refused counter write leaves value
      acc(2'd0, 1'b1, 4'd4, 32'hDEAD, st, rd);
      check("R10 status", 32'(st), 32'd1);
      acc(2'd2, 1'b0, 4'd4, 32'h0, st, rd);
      check("R10 counter kept", rd, 32'd15);

      done = 1'b1;
      summary();
   end
endmodule